// File: doc/BRIEF.md
# Link Reset Ordered-Set Sequencer

This block sequences the transmit side of a downstream-facing serial link port while the parallel bus behind it is held in reset. It counts one clock as one symbol time. When the active-low bus reset input goes low, the block pulls its active-low fundamental reset output low. It then asks the transmitter for a fixed burst of training sets, each carrying the hot-reset bit. While the burst runs, a symbol counter makes sure a skip set goes out often enough. After the last training set, the block sends one electrical-idle set and parks the lane in electrical idle.

Ordered sets are handed to the transmitter over a request/acknowledge pair. The request and its kind code stay fixed until the acknowledge arrives. The acknowledge cycle is the first symbol of that set on the wire. The block requests nothing further until the set's whole length has passed.

Skip sets are placed only between two sets and never count toward the training total. A late-skip flag rises if the gap since the previous skip grows past the upper bound. This happens when the transmitter holds off an acknowledge for too long.

The lane stays idle with the fundamental reset asserted until the bus reset is released. The block then returns to its ready state.

Top module: `lrs_seq`

## Requirements
- R1: After a synchronous reset (`rst` high), the outputs are `fund_rst_n`=1, `os_req`=0, `os_kind`=0, `elec_idle`=0 and `skp_late`=0. While `bus_rst_n` stays high in this state, no request is made.
- R2: In the ready state, a low `bus_rst_n` seen at a clock edge drives `fund_rst_n` low in the next cycle. In that same cycle a request of kind 1 (training set) appears.
- R3: Exactly 1024 training sets (`os_kind`=1) are accepted per burst. `os_hot_rst` is 1 with each of them and 0 with every other kind.
- R4: A pending request keeps `os_req` high and `os_kind` unchanged until `os_ack` is high. Nothing is counted without an acknowledge.
- R5: A set accepted in cycle k occupies the lane for its length. The length is 16 symbol times for a training set and 4 for a skip or idle set, so the next request first appears in cycle k+16 or k+4.
- R6: While fewer than 1024 training sets have been accepted, a request is a skip (`os_kind`=2) exactly when it first appears at least 1181 cycles after the previous skip handshake. For the first skip of a burst, the gap is counted from the edge that accepted the bus reset, taken as cycle 0. When acknowledges come without delay, consecutive skips are 1181 to 1538 cycles apart.
- R7: Once the 1024th training set has been accepted, the next request is one electrical-idle set (`os_kind`=3), with no skip before it.
- R8: `skp_late` is high in a cycle exactly when a burst is in progress (fundamental reset asserted, lane not idle) and at least 1538 cycles have passed since the previous skip handshake or burst start.
- R9: `elec_idle` rises 4 cycles after the idle set's handshake. No request is made while it is high.
- R10: While `bus_rst_n` stays low, `elec_idle` stays 1 and `fund_rst_n` stays 0. In the cycle after `bus_rst_n` is seen high, `fund_rst_n` is 1 and `elec_idle` is 0.
- R11: Raising `bus_rst_n` during a burst does not shorten it. All 1024 training sets and the idle set still go out before the reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol-time clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst_n | input | 1 | Active-low parallel bus reset |
| fund_rst_n | output | 1 | Active-low fundamental reset to the link partner |
| os_req | output | 1 | Ordered-set request to the transmitter |
| os_kind | output | 2 | Requested set: 0 none, 1 training, 2 skip, 3 electrical idle |
| os_hot_rst | output | 1 | Hot-reset bit carried by the requested training set |
| os_ack | input | 1 | Transmitter accepts the pending set; this cycle is its first symbol |
| elec_idle | output | 1 | Lane is in electrical idle |
| skp_late | output | 1 | Skip interval has reached its upper bound |

## Verification
The bench predicts, at every new request, whether a skip must be chosen. A design whose decision was one cycle off, or that skipped during the idle tail, would put a skip or training set where the other belongs. The gap from each handshake to the next request is checked against the set length, which catches a miscounted occupancy. In the second burst, one acknowledge is held back for 400 cycles. That pushes the skip gap past its bound, so it exposes a design that drops or alters its request, counts an unacknowledged set, or raises the late flag at the wrong count. The same burst releases the bus reset early, which catches a design that cuts the burst short. The first burst holds the reset through a long idle, which catches a premature release.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    typedef enum logic [1:0] {
        OS_NONE = 2'd0,
        OS_TS1  = 2'd1,
        OS_SKP  = 2'd2,
        OS_EIOS = 2'd3
    } os_kind_e;

    typedef enum logic [1:0] {
        ST_READY,
        ST_REQ,
        ST_WIRE,
        ST_EIDLE
    } seq_state_e;

    typedef struct packed {
        logic     req;
        os_kind_e kind;
        logic     hot;
    } os_drive_t;

    // Lane occupancy of one ordered set, in symbol times.
    function automatic int unsigned os_len(os_kind_e k, int unsigned ts_len,
                                           int unsigned skp_len, int unsigned ei_len);
        case (k)
            OS_TS1:  return ts_len;
            OS_SKP:  return skp_len;
            OS_EIOS: return ei_len;
            default: return 2;
        endcase
    endfunction

    // Choice of the next set at an ordered-set boundary.
    function automatic os_kind_e pick_next(logic burst_done, logic skip_due);
        if (burst_done)
            return OS_EIOS;
        else if (skip_due)
            return OS_SKP;
        return OS_TS1;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lrs_skp_timer.sv
module lrs_skp_timer #(
    parameter int unsigned SKP_NOM = 1180,
    parameter int unsigned SKP_MAX = 1538
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic due,
    output logic late
);
    localparam int unsigned W = $clog2(SKP_MAX + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= W'(1);
        else if (run && cnt_q < W'(SKP_MAX))
            cnt_q <= cnt_q + W'(1);
    end

    assign due  = cnt_q >= W'(SKP_NOM);
    assign late = run && (cnt_q >= W'(SKP_MAX));
endmodule

// File: rtl/lrs_ts_ctr.sv
module lrs_ts_ctr #(
    parameter int unsigned TS_COUNT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic done
);
    localparam int unsigned W = $clog2(TS_COUNT + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (inc && cnt_q != W'(TS_COUNT))
            cnt_q <= cnt_q + W'(1);
    end

    assign done = cnt_q == W'(TS_COUNT);
endmodule

// File: rtl/lrs_occ_timer.sv
module lrs_occ_timer #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] len,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] occ_q;

    // The handshake cycle and the request cycle that follows are not counted here.
    always_ff @(posedge clk) begin
        if (rst)
            occ_q <= '0;
        else if (load)
            occ_q <= len - W'(2);
        else if (run && occ_q != '0)
            occ_q <= occ_q - W'(1);
    end

    assign expired = occ_q == '0;
endmodule

// File: rtl/lrs_seq.sv
module lrs_seq
    import lrs_pkg::*;
#(
    parameter int unsigned TS_COUNT = 1024,
    parameter int unsigned SKP_NOM  = 1180,
    parameter int unsigned SKP_MAX  = 1538,
    parameter int unsigned TS_LEN   = 16,
    parameter int unsigned SKP_LEN  = 4,
    parameter int unsigned EI_LEN   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_rst_n,
    output logic       fund_rst_n,
    output logic       os_req,
    output logic [1:0] os_kind,
    output logic       os_hot_rst,
    input  logic       os_ack,
    output logic       elec_idle,
    output logic       skp_late
);
    localparam int unsigned MAX_LEN = max3(TS_LEN, SKP_LEN, EI_LEN);
    localparam int unsigned OCW     = $clog2(MAX_LEN + 1);

    seq_state_e state_q;
    os_kind_e   kind_q;
    os_drive_t  drv;

    logic           start, hs, ts_hs, skp_hs, in_burst, in_wire;
    logic           ts_done, skip_due, occ_expired, late_raw;
    logic [OCW-1:0] occ_len;

    assign start    = (state_q == ST_READY) && !bus_rst_n;
    assign hs       = (state_q == ST_REQ) && os_ack;
    assign ts_hs    = hs && (kind_q == OS_TS1);
    assign skp_hs   = hs && (kind_q == OS_SKP);
    assign in_wire  = state_q == ST_WIRE;
    assign in_burst = (state_q == ST_REQ) || in_wire;
    assign occ_len  = OCW'(os_len(kind_q, TS_LEN, SKP_LEN, EI_LEN));

    lrs_skp_timer #(
        .SKP_NOM(SKP_NOM),
        .SKP_MAX(SKP_MAX)
    ) i_skp (
        .clk    (clk),
        .rst    (rst),
        .restart(start || skp_hs),
        .run    (in_burst),
        .due    (skip_due),
        .late   (late_raw)
    );

    lrs_ts_ctr #(
        .TS_COUNT(TS_COUNT)
    ) i_ts (
        .clk (clk),
        .rst (rst),
        .clr (start),
        .inc (ts_hs),
        .done(ts_done)
    );

    lrs_occ_timer #(
        .W(OCW)
    ) i_occ (
        .clk    (clk),
        .rst    (rst),
        .load   (hs),
        .len    (occ_len),
        .run    (in_wire),
        .expired(occ_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READY;
            kind_q  <= OS_NONE;
        end else begin
            case (state_q)
                ST_READY: begin
                    if (start) begin
                        state_q <= ST_REQ;
                        kind_q  <= OS_TS1;
                    end
                end
                ST_REQ: begin
                    if (os_ack)
                        state_q <= ST_WIRE;
                end
                ST_WIRE: begin
                    if (occ_expired) begin
                        if (kind_q == OS_EIOS) begin
                            state_q <= ST_EIDLE;
                            kind_q  <= OS_NONE;
                        end else begin
                            state_q <= ST_REQ;
                            kind_q  <= pick_next(ts_done, skip_due);
                        end
                    end
                end
                default: begin
                    if (bus_rst_n)
                        state_q <= ST_READY;
                end
            endcase
        end
    end

    always_comb begin
        drv.req  = state_q == ST_REQ;
        drv.kind = drv.req ? kind_q : OS_NONE;
        drv.hot  = drv.req && (kind_q == OS_TS1);
    end

    assign os_req     = drv.req;
    assign os_kind    = drv.kind;
    assign os_hot_rst = drv.hot;
    assign fund_rst_n = state_q == ST_READY;
    assign elec_idle  = state_q == ST_EIDLE;
    assign skp_late   = late_raw;
endmodule

// File: rtl/lrs_chk.sv
module lrs_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_rst_n,
    input logic       fund_rst_n,
    input logic       os_req,
    input logic [1:0] os_kind,
    input logic       os_hot_rst,
    input logic       os_ack,
    input logic       elec_idle,
    input logic       skp_late
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        os_req && !os_ack |=> os_req && $stable(os_kind)); // R4

    AST_RST_FOLLOWS_BUS: assert property (@(posedge clk) disable iff (rst)
        fund_rst_n && !bus_rst_n |=> !fund_rst_n && os_req); // R2

    AST_REQ_UNDER_RST: assert property (@(posedge clk) disable iff (rst)
        os_req |-> !fund_rst_n && !elec_idle); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        elec_idle && !bus_rst_n |=> elec_idle && !fund_rst_n); // R10

    AST_IDLE_EXIT: assert property (@(posedge clk) disable iff (rst)
        elec_idle && bus_rst_n |=> fund_rst_n && !elec_idle); // R10

    AST_LATE_IN_BURST: assert property (@(posedge clk) disable iff (rst)
        skp_late |-> !fund_rst_n && !elec_idle); // R8

    AST_HOT_WITH_TS: assert property (@(posedge clk) disable iff (rst)
        os_hot_rst |-> os_req); // R3
endmodule

bind lrs_seq lrs_chk i_lrs_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rst_n (bus_rst_n),
    .fund_rst_n(fund_rst_n),
    .os_req    (os_req),
    .os_kind   (os_kind),
    .os_hot_rst(os_hot_rst),
    .os_ack    (os_ack),
    .elec_idle (elec_idle),
    .skp_late  (skp_late)
);

// File: tb/test_lrs_seq.sv
module test_lrs_seq;
    localparam int NTS     = 1024;
    localparam int SKP_DUE = 1181;
    localparam int SKP_MAX = 1538;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_rst_n = 1'b1;
    logic       os_ack = 1'b0;
    logic       fund_rst_n, os_req, os_hot_rst, elec_idle, skp_late;
    logic [1:0] os_kind;

    lrs_seq i_lrs_seq (
        .clk       (clk),
        .rst       (rst),
        .bus_rst_n (bus_rst_n),
        .fund_rst_n(fund_rst_n),
        .os_req    (os_req),
        .os_kind   (os_kind),
        .os_hot_rst(os_hot_rst),
        .os_ack    (os_ack),
        .elec_idle (elec_idle),
        .skp_late  (skp_late)
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // scoreboard of non-skip sets expected per burst
    logic [1:0] exp_q[$];

    // monitor state
    int  burst_id = 0;
    int  ref_cyc = 0, last_ack = -1, last_len = 0, eios_cyc = 0;
    int  ts_seen = 0, stall_left = 0, skips = 0;
    int  late_bad = 0, idle_req_bad = 0;
    bit  stalled = 0, prev_req = 0, prev_fund = 1, prev_idle = 0;
    bit  late_seen[3];
    int  ts_final[3];
    int  skip_cnt[3];
    logic [1:0] stall_kind;

    always @(negedge clk) begin
        int  e;
        bit  late_exp;
        logic [1:0] k;
        if (rst) begin
            os_ack = 1'b0;
        end else begin
            if (!fund_rst_n && prev_fund) begin
                burst_id++;
                ref_cyc = cyc - 1;
                last_ack = -1;
                ts_seen = 0;
                skips = 0;
                stalled = 0;
            end
            late_exp = !fund_rst_n && !elec_idle && (cyc - ref_cyc >= SKP_MAX);
            if (skp_late !== late_exp) late_bad++;
            if (skp_late && burst_id < 3) late_seen[burst_id] = 1;
            if (elec_idle && !prev_idle)
                chk(cyc == eios_cyc + 4, "R9 idle entry cycle", cyc - eios_cyc, 4);
            if (elec_idle && os_req) idle_req_bad++;
            if (os_req && !prev_req) begin
                e = cyc - ref_cyc;
                if (last_ack < 0)
                    chk(cyc == ref_cyc + 1, "R2 first request cycle", cyc - ref_cyc, 1);
                else
                    chk(cyc - last_ack == last_len, "R5 occupancy gap", cyc - last_ack, last_len);
                if (ts_seen < NTS)
                    chk((os_kind == 2'd2) == (e >= SKP_DUE), "R6 skip decision", os_kind, (e >= SKP_DUE) ? 2 : 1);
                else
                    chk(os_kind == 2'd3, "R7 idle set after burst", os_kind, 3);
                if (burst_id == 2 && !stalled && os_kind == 2'd1 && e >= 1150) begin
                    stall_left = 400;
                    stalled = 1;
                    stall_kind = os_kind;
                end
            end
            if (os_req) begin
                if (stall_left > 0) begin
                    stall_left--;
                    os_ack = 1'b0;
                    if (stall_left == 0)
                        chk(os_kind == stall_kind, "R4 request held", os_kind, stall_kind);
                end else begin
                    os_ack = 1'b1;
                    last_ack = cyc;
                    k = os_kind;
                    if (k == 2'd2) begin
                        last_len = 4;
                        skips++;
                        chk(!os_hot_rst, "R3 hot bit off on skip", os_hot_rst, 0);
                        if (burst_id == 1)
                            chk(cyc - ref_cyc >= SKP_DUE && cyc - ref_cyc <= SKP_MAX,
                                "R6 skip interval", cyc - ref_cyc, SKP_DUE);
                        ref_cyc = cyc;
                    end else begin
                        last_len = (k == 2'd1) ? 16 : 4;
                        if (exp_q.size() == 0)
                            chk(0, "R7 unexpected set", k, 0);
                        else
                            chk(k == exp_q.pop_front(), "R3 set order", k, 1);
                        if (k == 2'd1) begin
                            chk(os_hot_rst, "R3 hot bit on training set", os_hot_rst, 1);
                            ts_seen++;
                        end else begin
                            chk(!os_hot_rst, "R3 hot bit off on idle set", os_hot_rst, 0);
                            eios_cyc = cyc;
                            if (burst_id < 3) begin
                                ts_final[burst_id] = ts_seen;
                                skip_cnt[burst_id] = skips;
                            end
                        end
                    end
                end
            end else begin
                os_ack = 1'b0;
            end
            prev_req  = os_req;
            prev_fund = fund_rst_n;
            prev_idle = elec_idle;
        end
    end

    task automatic push_burst();
        for (int i = 0; i < NTS; i++) exp_q.push_back(2'd1);
        exp_q.push_back(2'd3);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!elec_idle);
    endtask

    task automatic run_all();
        int bad;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(fund_rst_n == 1, "R1 reset fund_rst_n", fund_rst_n, 1);
        chk(os_req == 0 && os_kind == 0, "R1 reset request", os_req, 0);
        chk(elec_idle == 0 && skp_late == 0, "R1 reset idle/late", elec_idle, 0);
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (os_req || !fund_rst_n) bad++;
        end
        chk(bad == 0, "R1 no request while bus reset high", bad, 0);

        // burst 1: prompt acknowledges, bus reset held long
        push_burst();
        bus_rst_n = 1'b0;
        wait_idle();
        bad = 0;
        repeat (200) begin
            @(negedge clk);
            if (!elec_idle || fund_rst_n) bad++;
        end
        chk(bad == 0, "R10 idle held under bus reset", bad, 0);
        bus_rst_n = 1'b1;
        @(negedge clk);
        chk(fund_rst_n == 1 && elec_idle == 0, "R10 release after bus reset", fund_rst_n, 1);
        chk(ts_final[1] == NTS, "R3 burst 1 training count", ts_final[1], NTS);
        chk(skip_cnt[1] > 0, "R6 burst 1 skips present", skip_cnt[1], 1);
        chk(late_seen[1] == 0, "R8 no late flag with prompt acks", late_seen[1], 0);
        repeat (10) @(negedge clk);

        // burst 2: one stalled acknowledge, bus reset released early
        push_burst();
        bus_rst_n = 1'b0;
        repeat (3000) @(negedge clk);
        bus_rst_n = 1'b1;
        chk(fund_rst_n == 0, "R11 burst continues after release", fund_rst_n, 0);
        wait_idle();
        @(negedge clk);
        chk(fund_rst_n == 1 && elec_idle == 0, "R10 exit with bus released", fund_rst_n, 1);
        chk(ts_final[2] == NTS, "R11 burst 2 training count", ts_final[2], NTS);
        chk(stalled, "R4 stall applied", stalled, 1);
        chk(late_seen[2] == 1, "R8 late flag after stall", late_seen[2], 1);
        chk(late_bad == 0, "R8 late flag cycles", late_bad, 0);
        chk(idle_req_bad == 0, "R9 no request in idle", idle_req_bad, 0);
        chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    endtask

    initial begin
        bit wd;
        wd = 0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd = 1;
            end
        join_any
        disable fork;
        if (wd) chk(0, "R9 watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule